// File: doc/BRIEF.md
# UART Auto-Baud Handshake Controller

This block brings up a serial link at power-on without knowing the host's bit rate ahead of time. The host keeps sending the all-zero byte in 8N1 format, with no parity and LSB first. Each of these frames holds the line low for nine bit-times: the start bit plus eight zero data bits. The block counts the clock cycles of one such low pulse and divides by nine, rounding to the nearest integer. It loads the result as the divisor of a small transmitter and receiver.

With the divisor set, the block transmits one 0x00 byte to tell the host that adjustment is done. It then listens for the host's reply. A 0x55 with a valid stop bit locks the link. Anything else leaves the block failed, and only a reset starts the measurement over. The block exposes the divisor, a locked flag and a failure flag.

Top module: `baud_lock_ctrl`

## Requirements
- R1: During and after reset, tx_o is high, locked_o and fail_o are low and divisor_o is 0.
- R2: Low pulses are measured only when they start after at least ARM_IDLE consecutive high cycles on the synchronized rx line. A low pulse that starts earlier is ignored: divisor_o stays 0 and no acknowledge is sent.
- R3: When a measured low pulse of N cycles ends, divisor_o takes the value (N+4)/9 using integer division, which is N/9 rounded to the nearest integer. After that it does not change until reset.
- R4: After the divisor is loaded, tx_o sends exactly one byte 0x00 as an 8N1 frame. Each bit lasts divisor_o cycles: a low start bit, eight data bits with bit 0 first, then a high stop bit. At all other times tx_o is high.
- R5: After the acknowledge frame has been sent, a received byte 0x55 whose stop bit is high sets locked_o.
- R6: After the acknowledge frame has been sent, a received byte other than 0x55 sets fail_o, and locked_o stays low.
- R7: A received frame whose stop bit is sampled low sets fail_o, whatever its data bits.
- R8: fail_o is set, and divisor_o stays 0, in either of two cases: the measured low pulse lasts longer than 2^CNT_W-1 cycles, or it rounds to a divisor below 2.
- R9: Once set, locked_o and fail_o stay set until reset. Later rx traffic changes neither flag nor divisor_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts measurement |
| rx_i | input | 1 | Serial receive line from the host (asynchronous) |
| tx_o | output | 1 | Serial transmit line to the host, idle high |
| locked_o | output | 1 | Handshake completed with 0x55 |
| fail_o | output | 1 | Handshake failed; held until reset |
| divisor_o | output | CNT_W-3 | Clock cycles per bit derived from the measurement |

## Verification
The bench aims at the rounding boundary, using pulses of 9·B+4 and 9·B+5 cycles. A design that truncates, or that adds the wrong bias, reports the neighbouring divisor. It also checks that a pulse following too short an idle is ignored. A design that arms at once would lock onto a mid-frame edge and send an acknowledge at a wrong rate. Finally, it forces an overlong pulse, a tiny pulse, a wrong confirm byte and a low stop bit. A design that wraps its counter, accepts divisor 1 or treats any byte as a confirm would lock where it must fail, or would clear a flag that must stay set.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_MEAS, ST_ACK, ST_WAIT, ST_LOCK, ST_FAIL
  } hs_state_e;

  localparam logic [7:0] ACK_BYTE     = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;
  localparam int unsigned LOW_BITS    = 9;

  // Nearest-integer bit period from a nine-bit low count
  function automatic int unsigned round_div9(input int unsigned n);
    return (n + LOW_BITS / 2) / LOW_BITS;
  endfunction
endpackage

// File: rtl/abd_sync.sv
module abd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/abd_meter.sv
module abd_meter #(
  parameter int CNT_W    = 16,
  parameter int ARM_IDLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             line_i,
  output logic             done_o,
  output logic             sat_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int IDLE_W = $clog2(ARM_IDLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [IDLE_W-1:0] idle_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              meas_q;
  logic              armed;

  assign armed = (idle_q == IDLE_W'(ARM_IDLE));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      idle_q <= '0;
      cnt_q  <= '0;
      meas_q <= 1'b0;
    end else if (meas_q) begin
      if (line_i) begin
        meas_q <= 1'b0;
        idle_q <= IDLE_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (line_i) begin
      if (!armed) idle_q <= idle_q + 1'b1;
    end else begin
      idle_q <= '0;
      if (armed) begin
        meas_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end
    end
  end

  assign done_o = en_i && meas_q && line_i;
  assign sat_o  = en_i && meas_q && !line_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  // R2: a measurement only opens from the armed idle state
  a_r2_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_q) |-> $past(armed));
endmodule

// File: rtl/abd_tx.sv
module abd_tx #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tx_o,
  output logic             done_o
);
  logic [9:0]       frame_q;
  logic [3:0]       bit_q;
  logic [DIV_W-1:0] cyc_q;
  logic             busy_q;
  logic             bit_end;

  assign bit_end = (cyc_q == div_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      bit_q   <= '0;
      cyc_q   <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        frame_q <= {1'b1, data_i, 1'b0};
        bit_q   <= '0;
        cyc_q   <= '0;
        busy_q  <= 1'b1;
      end
    end else if (bit_end) begin
      cyc_q <= '0;
      if (bit_q == 4'd9) begin
        busy_q <= 1'b0;
      end else begin
        bit_q   <= bit_q + 1'b1;
        frame_q <= {1'b1, frame_q[9:1]};
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign tx_o   = busy_q ? frame_q[0] : 1'b1;
  assign done_o = busy_q && bit_end && (bit_q == 4'd9);

  // R4: the frame ends on the stop bit, so the line is high at completion
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> tx_o);
endmodule

// File: rtl/abd_rx.sv
module abd_rx #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             line_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             ferr_o
);
  logic             act_q;
  logic [3:0]       bit_q;
  logic [DIV_W-1:0] cyc_q;
  logic [7:0]       sh_q;
  logic [DIV_W-1:0] target;
  logic             hit;

  // First sample lands mid start bit, the rest one period apart
  assign target = (bit_q == 4'd0) ? (div_i >> 1) : (div_i - 1'b1);
  assign hit    = act_q && (cyc_q == target);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      act_q <= 1'b0;
      bit_q <= '0;
      cyc_q <= '0;
      sh_q  <= '0;
    end else if (!act_q) begin
      if (!line_i) begin
        act_q <= 1'b1;
        bit_q <= '0;
        cyc_q <= '0;
      end
    end else if (hit) begin
      cyc_q <= '0;
      if (bit_q == 4'd0) begin
        if (line_i) act_q <= 1'b0;
        else        bit_q <= 4'd1;
      end else if (bit_q == 4'd9) begin
        act_q <= 1'b0;
      end else begin
        sh_q  <= {line_i, sh_q[7:1]};
        bit_q <= bit_q + 1'b1;
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign valid_o = hit && (bit_q == 4'd9);
  assign data_o  = sh_q;
  assign ferr_o  = !line_i;

  // R5: a received byte is reported for one cycle only
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/baud_lock_ctrl.sv
module baud_lock_ctrl
  import abd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ARM_IDLE = 16,
  parameter int MIN_DIV  = 2,
  localparam int DIV_W   = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             locked_o,
  output logic             fail_o,
  output logic [DIV_W-1:0] divisor_o
);
  hs_state_e        state_q;
  logic [DIV_W-1:0] divisor_q;
  logic             go_q;
  logic             rx_s;
  logic             meas_done, meas_sat;
  logic [CNT_W-1:0] meas_cnt;
  logic [DIV_W-1:0] div_calc;
  logic             tx_done;
  logic             rx_valid, rx_ferr;
  logic [7:0]       rx_data;

  abd_sync u_sync (.clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s));

  abd_meter #(.CNT_W(CNT_W), .ARM_IDLE(ARM_IDLE)) u_meter (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_MEAS), .line_i(rx_s),
    .done_o(meas_done), .sat_o(meas_sat), .cnt_o(meas_cnt));

  abd_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(go_q), .data_i(ACK_BYTE),
    .div_i(divisor_q), .tx_o(tx_o), .done_o(tx_done));

  abd_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_WAIT), .line_i(rx_s),
    .div_i(divisor_q), .valid_o(rx_valid), .data_o(rx_data), .ferr_o(rx_ferr));

  assign div_calc = DIV_W'(round_div9(32'(meas_cnt)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_MEAS;
      divisor_q <= '0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_MEAS: begin
          if (meas_sat) begin
            state_q <= ST_FAIL;
          end else if (meas_done) begin
            if (div_calc < DIV_W'(MIN_DIV)) begin
              state_q <= ST_FAIL;
            end else begin
              divisor_q <= div_calc;
              go_q      <= 1'b1;
              state_q   <= ST_ACK;
            end
          end
        end
        ST_ACK:  if (tx_done) state_q <= ST_WAIT;
        ST_WAIT: if (rx_valid)
                   state_q <= (!rx_ferr && rx_data == CONFIRM_BYTE) ? ST_LOCK : ST_FAIL;
        default: state_q <= state_q;
      endcase
    end
  end

  assign locked_o  = (state_q == ST_LOCK);
  assign fail_o    = (state_q == ST_FAIL);
  assign divisor_o = divisor_q;

  // R9: both outcome flags are sticky
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o);
  // R3: the divisor only moves while measuring
  a_r3_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_MEAS) |=> $stable(divisor_q));
  // R4: line stays idle outside the acknowledge phase
  a_r4_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ACK) |-> tx_o);
  // R5: lock only follows a clean confirm byte
  a_r5_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(rx_valid && !rx_ferr && rx_data == CONFIRM_BYTE));
endmodule

// File: tb/baud_lock_ctrl_bench.sv
module baud_lock_ctrl_bench;
  localparam int CNT_W = 12;
  localparam int DIV_W = CNT_W - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx, locked, fail;
  logic [DIV_W-1:0] divisor;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  baud_lock_ctrl #(.CNT_W(CNT_W), .ARM_IDLE(16)) u_baud_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
    .locked_o(locked), .fail_o(fail), .divisor_o(divisor));

  function automatic int exp_div(input int n);
    int q;
    q = n / 9;
    if (n - q * 9 >= 5) q++;
    return q;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(40);
  endtask

  task automatic send_low(input int n);
    rx = 1'b0;
    wait_n(n);
    rx = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int per, input bit stop_ok);
    rx = 1'b0;
    wait_n(per);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      wait_n(per);
    end
    rx = stop_ok;
    wait_n(per);
    rx = 1'b1;
    wait_n(per);
  endtask

  task automatic recv_byte(input int per, output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1'b0;
    b = 8'hxx;
    while (tx !== 1'b0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (tx !== 1'b0) return;
    wait_n(per / 2);
    if (tx !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin
      wait_n(per);
      b[i] = tx;
    end
    wait_n(per);
    ok = (tx === 1'b1);
  endtask

  task automatic to_wait(input int per);
    logic [7:0] b;
    bit ok;
    send_low(9 * per);
    recv_byte(per, b, ok);
    chk(ok && b == 8'h00, "R4 ack byte", int'(b), 0);
    wait_n(per);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    wait_n(3);
    chk(tx == 1'b1, "R1 tx idle in reset", tx, 1);
    rst_n = 1'b1;
    wait_n(2);
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(!locked && !fail, "R1 flags clear", {locked, fail}, 0);
    chk(divisor == 0, "R1 divisor zero", divisor, 0);
  endtask

  task automatic t_handshake();
    logic [7:0] b;
    bit ok;
    do_reset();
    send_low(180);
    wait_n(4);
    chk(divisor == 20, "R3 divisor B=20", divisor, 20);
    recv_byte(20, b, ok);
    chk(ok, "R4 ack frame stop bit", ok, 1);
    chk(b == 8'h00, "R4 ack byte value", b, 0);
    wait_n(20);
    send_byte(8'h55, 20, 1'b1);
    wait_n(4);
    chk(locked == 1'b1, "R5 locked after 0x55", locked, 1);
    chk(fail == 1'b0, "R5 no fail", fail, 0);
    send_byte(8'h12, 20, 1'b1);
    send_low(300);
    wait_n(20);
    chk(locked && !fail, "R9 lock held after traffic", locked, 1);
    chk(divisor == 20, "R9 divisor held", divisor, 20);
    chk(tx == 1'b1, "R9 no extra tx", tx, 1);
  endtask

  task automatic t_round();
    int lens[3] = '{9 * 33 + 4, 9 * 33 + 5, 9 * 33 - 4};
    foreach (lens[i]) begin
      do_reset();
      send_low(lens[i]);
      wait_n(4);
      chk(divisor == exp_div(lens[i]), "R3 rounding", divisor, exp_div(lens[i]));
    end
  endtask

  task automatic t_bad_byte();
    do_reset();
    to_wait(20);
    send_byte(8'h54, 20, 1'b1);
    wait_n(4);
    chk(fail && !locked, "R6 wrong confirm fails", {locked, fail}, 1);
    send_byte(8'h55, 20, 1'b1);
    wait_n(4);
    chk(fail && !locked, "R9 fail held", {locked, fail}, 1);
  endtask

  task automatic t_framing();
    do_reset();
    to_wait(24);
    send_byte(8'h55, 24, 1'b0);
    wait_n(4);
    chk(fail && !locked, "R7 low stop fails", {locked, fail}, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    send_low(5000);
    wait_n(10);
    chk(fail == 1'b1, "R8 overlong pulse fails", fail, 1);
    chk(divisor == 0, "R8 divisor stays zero", divisor, 0);
    do_reset();
    send_low(10);
    wait_n(10);
    chk(fail == 1'b1, "R8 tiny pulse fails", fail, 1);
    chk(divisor == 0 && tx == 1'b1, "R8 no ack on tiny pulse", divisor, 0);
  endtask

  task automatic t_arm();
    rst_n = 1'b0;
    rx = 1'b1;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    send_low(90);
    wait_n(10);
    chk(divisor == 0, "R2 unarmed pulse ignored", divisor, 0);
    chk(tx == 1'b1 && !fail, "R2 no ack unarmed", tx, 1);
    wait_n(40);
    send_low(180);
    wait_n(4);
    chk(divisor == 20, "R2 armed pulse measured", divisor, 20);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_handshake();
    t_round();
    t_bad_byte();
    t_framing();
    t_saturate();
    t_arm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule